// File: doc/BRIEF.md
# Horizontal Chroma Subsampler and Interpolator

This block sits in a video pixel path and moves chroma between full horizontal rate and half rate. In the compress direction it takes one luma and two chroma samples per pixel. It keeps the chroma of even pixels only and puts it out on a single chroma lane, with Cr and Cb taking turns beside the luma. In the decompress direction it takes that interleaved lane apart again. The red-difference and blue-difference values of each even pixel are repeated onto the odd pixel that follows it, so full-rate chroma comes back without any filtering.

The resampling is done only for the two pixel formats that carry three full components: RGB (code 7h) and YCrCb (code 6h). For every other format code the three lanes pass through untouched, with the same delay. Pixels arrive one every `CLK_PER_PIX` clocks within a line (two by default, so the pixel rate is half the clock). Each pixel may carry a start-of-line and an end-of-line flag. Lines may be separated by any idle gap. The stream is fixed-rate and has no back-pressure: the consumer must take every output beat in the cycle it is valid. `dir_comp` and `fmt` must stay steady from the first pixel of a line until that line has left the output.

Top module: `chroma_resampler`

## Requirements
- R1: Every accepted pixel leaves exactly 4 clock cycles (2 pixel times) after the cycle in which it was presented, with its Y value and its start/end-of-line flags unchanged. No output beat appears without a matching input pixel.
- R2: In compress mode (`dir_comp`=1, `fmt` 7h or 6h), `out_cr` carries the chroma lane. For an even pixel it is that pixel's own Cr. For an odd pixel it is the Cb of the even pixel just before it. The odd pixel's own Cr and Cb are dropped, and `out_cb` is always 0.
- R3: In decompress mode (`dir_comp`=0, `fmt` 7h or 6h), the chroma lane is read from `in_cr`. An even pixel outputs its own lane value as Cr and the next pixel's lane value as Cb. An odd pixel repeats the Cr and Cb of the even pixel before it.
- R4: A pixel flagged `in_sol` is always treated as even (pixel 0 of its line), whatever the parity at which the previous line ended.
- R5: In decompress mode, if a line ends on an even pixel (odd pixel count), that pixel outputs its own lane value as Cr and 0 as Cb.
- R6: For any `fmt` other than 7h and 6h, `out_y`, `out_cr` and `out_cb` equal `in_y`, `in_cr` and `in_cb` of the same pixel, in either direction.
- R7: In decompress mode with resampling active, `in_cb` has no effect on any output.
- R8: After reset, `out_valid`, `out_sol` and `out_eol` are 0 and all output data lanes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_comp | input | 1 | 1 = compress (subsample), 0 = decompress (interpolate) |
| fmt | input | 4 | Pixel format code; 7h and 6h enable resampling |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sol | input | 1 | Input pixel is the first of its line |
| in_eol | input | 1 | Input pixel is the last of its line |
| in_y | input | 8 | Luma, unsigned |
| in_cr | input | 8 | Cr (two's complement), or the chroma lane when decompressing |
| in_cb | input | 8 | Cb (two's complement); unused when decompressing |
| out_valid | output | 1 | Output pixel present this cycle |
| out_sol | output | 1 | Output pixel is the first of its line |
| out_eol | output | 1 | Output pixel is the last of its line |
| out_y | output | 8 | Luma, aligned with its chroma |
| out_cr | output | 8 | Cr, or the interleaved chroma lane when compressing |
| out_cb | output | 8 | Cb; 0 when compressing |

## Verification
Every result of this block is due exactly four clock cycles after its pixel is presented. For an even decompressed pixel, that is also two cycles after the odd partner that supplies its Cb has arrived. The bench stamps each pixel with the cycle count at which it is driven. It then requires the matching output beat in the cycle whose count is that stamp plus four, and it compares Y, Cr and Cb there against values it derives from whole lines. Outputs are sampled on the falling edge, after the register that drives them has settled. Before each direction or format change, the bench waits until the line in flight has fully left the block, so no beat is checked against settings it did not see.

// File: rtl/csi_pkg.sv
package csi_pkg;
  localparam int unsigned DW = 8;

  typedef logic [3:0] fmt_t;

  localparam fmt_t FMT_RGB = 4'h7;
  localparam fmt_t FMT_YCC = 4'h6;

  typedef struct packed {
    logic          v;
    logic          sol;
    logic          eol;
    logic [DW-1:0] y;
    logic [DW-1:0] c0;
    logic [DW-1:0] c1;
  } pix_t;

  function automatic logic resample_on(fmt_t f);
    return (f == FMT_RGB) || (f == FMT_YCC);
  endfunction
endpackage

// File: rtl/csi_delay.sv
module csi_delay
  import csi_pkg::*;
#(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned TAP   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pix_t          d,
  output pix_t          q_last,
  output logic          tap_v,
  output logic [DW-1:0] tap_c
);
  pix_t st [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= '0;
        else        st[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= '0;
        else        st[i] <= st[i-1];
      end
    end
  end

  assign q_last = st[DEPTH-1];
  assign tap_v  = st[TAP].v;
  assign tap_c  = st[TAP].c0;
endmodule

// File: rtl/csi_phase.sv
module csi_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_v,
  input  logic pix_sol,
  input  logic pix_eol,
  output logic even
);
  logic odd_q;

  // Line start forces even; otherwise parity alternates per pixel.
  assign even = pix_sol | ~odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     odd_q <= 1'b0;
    else if (pix_v) odd_q <= pix_eol ? 1'b0 : even;
  end
endmodule

// File: rtl/csi_convert.sv
module csi_convert
  import csi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on,
  input  logic          dir_comp,
  input  pix_t          head,
  input  logic          even,
  input  logic          nxt_v,
  input  logic [DW-1:0] nxt_c,
  output logic          out_valid,
  output logic          out_sol,
  output logic          out_eol,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_cr,
  output logic [DW-1:0] out_cb
);
  logic [DW-1:0] hold_q, hold_n, cr_n, cb_n;

  always_comb begin
    cr_n   = head.c0;
    cb_n   = head.c1;
    hold_n = hold_q;
    if (on) begin
      if (dir_comp) begin
        cb_n = '0;
        if (even) begin
          cr_n   = head.c0;
          hold_n = head.c1;
        end else begin
          cr_n = hold_q;
        end
      end else begin
        if (even) begin
          cr_n   = head.c0;
          cb_n   = (head.eol || !nxt_v) ? '0 : nxt_c;
          hold_n = head.c0;
        end else begin
          cr_n = hold_q;
          cb_n = head.c0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_eol   <= 1'b0;
      out_y     <= '0;
      out_cr    <= '0;
      out_cb    <= '0;
    end else begin
      out_valid <= head.v;
      out_sol   <= head.v & head.sol;
      out_eol   <= head.v & head.eol;
      if (head.v) begin
        hold_q <= hold_n;
        out_y  <= head.y;
        out_cr <= cr_n;
        out_cb <= cb_n;
      end
    end
  end
endmodule

// File: rtl/chroma_resampler.sv
module chroma_resampler
  import csi_pkg::*;
#(
  parameter int unsigned CLK_PER_PIX = 2,
  parameter int unsigned LAT_PIX     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_comp,
  input  logic [3:0]    fmt,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic          in_eol,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_cr,
  input  logic [DW-1:0] in_cb,
  output logic          out_valid,
  output logic          out_sol,
  output logic          out_eol,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_cr,
  output logic [DW-1:0] out_cb
);
  // Total latency in clocks; the output register supplies one of them.
  localparam int unsigned LAT_CLK = LAT_PIX * CLK_PER_PIX;
  localparam int unsigned N_STG   = LAT_CLK - 1;
  // The next pixel of the line sits CLK_PER_PIX stages behind the head.
  localparam int unsigned AHEAD   = N_STG - 1 - CLK_PER_PIX;

  pix_t          in_pix, head;
  logic          nxt_v, even, on;
  logic [DW-1:0] nxt_c;

  assign in_pix = '{v: in_valid, sol: in_valid & in_sol, eol: in_valid & in_eol,
                    y: in_y, c0: in_cr, c1: in_cb};
  assign on     = resample_on(fmt);

  csi_delay #(.DEPTH(N_STG), .TAP(AHEAD)) dly_i (
    .clk(clk), .rst_n(rst_n), .d(in_pix),
    .q_last(head), .tap_v(nxt_v), .tap_c(nxt_c)
  );

  csi_phase ph_i (
    .clk(clk), .rst_n(rst_n), .pix_v(head.v),
    .pix_sol(head.sol), .pix_eol(head.eol), .even(even)
  );

  csi_convert cv_i (
    .clk(clk), .rst_n(rst_n), .on(on), .dir_comp(dir_comp),
    .head(head), .even(even), .nxt_v(nxt_v), .nxt_c(nxt_c),
    .out_valid(out_valid), .out_sol(out_sol), .out_eol(out_eol),
    .out_y(out_y), .out_cr(out_cr), .out_cb(out_cb)
  );
endmodule

// File: rtl/chroma_resampler_chk.sv
module chroma_resampler_chk #(
  parameter int unsigned LAT_CLK = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dir_comp,
  input logic [3:0] fmt,
  input logic       in_valid,
  input logic [7:0] in_y,
  input logic [7:0] in_cr,
  input logic [7:0] in_cb,
  input logic       out_valid,
  input logic       out_sol,
  input logic       out_eol,
  input logic [7:0] out_y,
  input logic [7:0] out_cr,
  input logic [7:0] out_cb
);
  logic       vsh [LAT_CLK];
  logic [7:0] ysh [LAT_CLK];
  logic [7:0] rsh [LAT_CLK];
  logic [7:0] bsh [LAT_CLK];
  logic       odd_q, is_even, act;
  logic [7:0] prev_cr, prev_cb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT_CLK; i++) begin
        vsh[i] <= 1'b0; ysh[i] <= '0; rsh[i] <= '0; bsh[i] <= '0;
      end
    end else begin
      vsh[0] <= in_valid; ysh[0] <= in_y; rsh[0] <= in_cr; bsh[0] <= in_cb;
      for (int i = 1; i < LAT_CLK; i++) begin
        vsh[i] <= vsh[i-1]; ysh[i] <= ysh[i-1];
        rsh[i] <= rsh[i-1]; bsh[i] <= bsh[i-1];
      end
    end
  end

  assign act     = (fmt == 4'h7) || (fmt == 4'h6);
  assign is_even = out_sol || !odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_q <= 1'b0; prev_cr <= '0; prev_cb <= '0;
    end else if (out_valid) begin
      odd_q   <= out_eol ? 1'b0 : is_even;
      prev_cr <= out_cr;
      prev_cb <= out_cb;
    end
  end

  // R1
  lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vsh[LAT_CLK-1]);
  // R1
  y_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_y == ysh[LAT_CLK-1]);
  // R2
  comp_cb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dir_comp && act) |-> out_cb == 8'h00);
  // R4
  comp_sol_cr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dir_comp && act && out_sol) |-> out_cr == rsh[LAT_CLK-1]);
  // R3
  exp_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !dir_comp && act && !is_even) |-> (out_cr == prev_cr && out_cb == prev_cb));
  // R5
  exp_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !dir_comp && act && is_even && out_eol) |-> out_cb == 8'h00);
  // R6
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !act) |-> (out_cr == rsh[LAT_CLK-1] && out_cb == bsh[LAT_CLK-1]));
endmodule

bind chroma_resampler chroma_resampler_chk #(.LAT_CLK(LAT_PIX * CLK_PER_PIX)) chk_i (
  .clk(clk), .rst_n(rst_n), .dir_comp(dir_comp), .fmt(fmt),
  .in_valid(in_valid), .in_y(in_y), .in_cr(in_cr), .in_cb(in_cb),
  .out_valid(out_valid), .out_sol(out_sol), .out_eol(out_eol),
  .out_y(out_y), .out_cr(out_cr), .out_cb(out_cb)
);

// File: tb/chroma_resampler_tb_top.sv
`timescale 1ns/1ps
module chroma_resampler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_comp = 1'b0;
  logic [3:0] fmt = 4'h0;
  logic       in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
  logic [7:0] in_y = '0, in_cr = '0, in_cb = '0;
  logic       out_valid, out_sol, out_eol;
  logic [7:0] out_y, out_cr, out_cb;

  always #2.5 clk = ~clk;

  chroma_resampler dut_i (
    .clk(clk), .rst_n(rst_n), .dir_comp(dir_comp), .fmt(fmt),
    .in_valid(in_valid), .in_sol(in_sol), .in_eol(in_eol),
    .in_y(in_y), .in_cr(in_cr), .in_cb(in_cb),
    .out_valid(out_valid), .out_sol(out_sol), .out_eol(out_eol),
    .out_y(out_y), .out_cr(out_cr), .out_cb(out_cb)
  );

  int nchk = 0, nbad = 0, cyc = 0, wr = 0, rd = 0;
  logic done = 1'b0;
  logic [7:0] ey [1024];
  logic [7:0] er [1024];
  logic [7:0] eb [1024];
  int         ec [1024];
  string      et [1024];

  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      nchk++;
      if (rd >= wr) begin
        nbad++;
        $display("FAIL R1 unexpected beat: got y=%02h expected no beat", out_y);
      end else begin
        if (cyc != ec[rd]) begin
          nbad++;
          $display("FAIL R1 latency: got cycle %0d expected %0d", cyc, ec[rd]);
        end else if (out_y != ey[rd] || out_cr != er[rd] || out_cb != eb[rd]) begin
          nbad++;
          $display("FAIL %s pixel %0d: got y=%02h cr=%02h cb=%02h expected y=%02h cr=%02h cb=%02h",
                   et[rd], rd, out_y, out_cr, out_cb, ey[rd], er[rd], eb[rd]);
        end
        rd++;
      end
    end
  end

  task automatic send_line(input int len, input int seed);
    logic [7:0] y [16];
    logic [7:0] r [16];
    logic [7:0] b [16];
    logic act;
    act = (fmt == 4'h7) || (fmt == 4'h6);
    for (int n = 0; n < len; n++) begin
      y[n] = 8'((seed * 29 + n * 13 + 5) & 255);
      r[n] = 8'((seed * 53 + n * 71 + 128) & 255);
      b[n] = 8'((seed * 19 + n * 97 + 200) & 255);
    end
    for (int n = 0; n < len; n++) begin
      ey[wr + n] = y[n];
      if (!act) begin
        er[wr + n] = r[n]; eb[wr + n] = b[n]; et[wr + n] = "R6";
      end else if (dir_comp) begin
        er[wr + n] = (n % 2 == 0) ? r[n] : b[n-1];
        eb[wr + n] = 8'h00;
        et[wr + n] = (n == 0) ? "R4" : "R2";
      end else begin
        if (n % 2 == 0) begin
          er[wr + n] = r[n];
          eb[wr + n] = (n + 1 < len) ? r[n+1] : 8'h00;
        end else begin
          er[wr + n] = r[n-1]; eb[wr + n] = r[n];
        end
        if (n == len - 1 && n % 2 == 0) et[wr + n] = "R5";
        else if (n == 0)                et[wr + n] = "R4";
        else                            et[wr + n] = "R3/R7";
      end
    end
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sol = (n == 0); in_eol = (n == len - 1);
      in_y = y[n]; in_cr = r[n];
      // R7: decompress drives a junk value on in_cb; it must not matter.
      in_cb = (act && !dir_comp) ? ~b[n] : b[n];
      ec[wr] = cyc + 4;
      wr++;
      @(negedge clk);
      in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    nchk++;
    if (out_valid || out_sol || out_eol || out_y != 0 || out_cr != 0 || out_cb != 0) begin
      nbad++;
      $display("FAIL R8 reset: got v=%0b y=%02h cr=%02h cb=%02h expected all 0",
               out_valid, out_y, out_cr, out_cb);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      for (int f = 0; f < 8; f++) begin
        dir_comp = d[0];
        fmt = 4'(f);
        for (int len = 1; len <= 9; len++) send_line(len, d * 40 + f * 5 + len);
        repeat (8) @(negedge clk);
      end
    end
    // R1: every expected beat must have come out
    nchk++;
    if (rd != wr) begin
      nbad++;
      $display("FAIL R1 beat count: got %0d expected %0d", rd, wr);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL R1 watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule